// File: doc/BRIEF.md
# Packet FIFO with Hysteresis Flow Flags

This block is a single-clock queue placed between a client that writes packet words and a transmit MAC that reads them. Each entry holds one 64-bit data word together with a start marker, an end marker and a 3-bit count of unused bytes, which is meaningful on the end word. The write side faces the client and the read side faces the MAC. Occupancy, free space and all thresholds are counted in whole entries.

Two registered flags regulate the traffic. The writer sees `room_ok`, which tells it whether it may keep sending. The reader sees `data_ok`, which tells it whether enough words are queued to start a read burst. Each flag has its own pair of programmable levels: one level makes the flag fall, and a second, higher level makes it rise again. The gap between the two levels gives the flag hysteresis and stops it from toggling on every word.

The reader pulls words with `rd_req`. The data output is registered, so a word appears in the cycle after it is requested. One word may therefore still arrive after `rd_req` drops. A write into a full queue is dropped and sets a sticky overflow indication. A request to an empty queue is ignored.

Top module: `pktq_hyst_fifo`

## Requirements
- R1: After synchronous reset the queue holds no words, `rd_valid` is 0, `data_ok` is 0, `room_ok` is 1 and `overflow` is 0.
- R2: Words leave in the order they were written, with data, start marker, end marker and 3-bit empty count unchanged. A word requested in cycle N is presented with `rd_valid` high in cycle N+1.
- R3: A write is accepted only if the queue was not full at the start of the cycle, even when a read is accepted in the same cycle. A rejected write leaves the contents unchanged and sets `overflow`, which stays 1 until reset.
- R4: A request while the queue is empty gives `rd_valid` 0 in the next cycle and removes nothing.
- R5: `room_ok` falls when the free entry count (16 minus occupancy) becomes less than or equal to `afull_on`.
- R6: Once low, `room_ok` rises only when the free count is at least `afull_off` and greater than `afull_on`. An `afull_off` below `afull_on` acts as equal to `afull_on`.
- R7: `data_ok` falls when occupancy becomes less than or equal to `aempty_on`.
- R8: Once low, `data_ok` rises only when occupancy is at least `aempty_off` and greater than `aempty_on`. An `aempty_off` below `aempty_on` acts as equal to `aempty_on`.
- R9: After `rd_req` is low in a cycle, `rd_valid` is low in the following cycle. So at most one word follows the drop of the request.
- R10: While `rd_req` stays high and the queue is not empty, `rd_valid` is high in every following cycle, with no gaps inside a packet.
- R11: A read and a write accepted in the same cycle leave the occupancy unchanged, and both flags keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| afull_on | input | 5 | Free-entry level at or below which `room_ok` falls |
| afull_off | input | 5 | Free-entry level at which `room_ok` rises again |
| aempty_on | input | 5 | Occupancy at or below which `data_ok` falls |
| aempty_off | input | 5 | Occupancy at which `data_ok` rises again |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 64 | Write data word |
| wr_sop | input | 1 | Word starts a packet |
| wr_eop | input | 1 | Word ends a packet |
| wr_empty | input | 3 | Unused bytes in an end word |
| room_ok | output | 1 | Writer may keep sending |
| overflow | output | 1 | Sticky: a write was dropped while full |
| rd_req | input | 1 | Reader requests one word this cycle |
| rd_valid | output | 1 | Read outputs hold a word |
| rd_data | output | 64 | Read data word |
| rd_sop | output | 1 | Start marker of read word |
| rd_eop | output | 1 | End marker of read word |
| rd_empty | output | 3 | Empty count of read word |
| data_ok | output | 1 | Enough data queued for the reader |

## Verification
A read and a write can fall in the same cycle. Near full, that same cycle can also carry a rejected write and the setting of the overflow flag. Directed runs fill the queue to 16 and then drive a write together with a request, so that one word leaves while the write is dropped. Random phases with independent write and read probabilities produce many same-cycle read-write pairs at every occupancy. A bench model judges each cycle: it applies acceptance from the occupancy at the start of the cycle, then updates both hysteresis flags from the new occupancy.

// File: rtl/pktq_pkg.sv
package pktq_pkg;
    localparam int DATA_W  = 64;
    localparam int EMPTY_W = 3;
    localparam int DEPTH   = 16;
    localparam int CNT_W   = $clog2(DEPTH + 1);
    localparam int ADDR_W  = $clog2(DEPTH);

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        logic               sop;
        logic               eop;
        logic [EMPTY_W-1:0] empty;
        logic [DATA_W-1:0]  data;
    } word_t;

    // rise level: an off level below the on level counts as the on level
    function automatic cnt_t rise_level(input cnt_t on_lvl, input cnt_t off_lvl);
        return (off_lvl < on_lvl) ? on_lvl : off_lvl;
    endfunction
endpackage

// File: rtl/pktq_store.sv
module pktq_store
    import pktq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  word_t wr_word,
    input  logic  rd_req,
    output logic  rd_valid,
    output word_t rd_word,
    output cnt_t  count,
    output cnt_t  count_nxt,
    output logic  wr_drop
);
    localparam cnt_t             FULL_C = cnt_t'(DEPTH);
    localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(DEPTH - 1);

    word_t             mem [DEPTH];
    logic [ADDR_W-1:0] wptr, rptr;
    logic              full, empty, wr_acc, rd_acc;

    assign full    = (count == FULL_C);
    assign empty   = (count == '0);
    assign wr_acc  = wr_en && !full;
    assign rd_acc  = rd_req && !empty;
    assign wr_drop = wr_en && full;

    always_comb begin
        count_nxt = count;
        if (wr_acc && !rd_acc)
            count_nxt = count + 1'b1;
        else if (!wr_acc && rd_acc)
            count_nxt = count - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (wr_acc)
            mem[wptr] <= wr_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr     <= '0;
            rptr     <= '0;
            count    <= '0;
            rd_valid <= 1'b0;
            rd_word  <= '0;
        end else begin
            count    <= count_nxt;
            rd_valid <= rd_acc;
            if (wr_acc)
                wptr <= (wptr == LAST_A) ? '0 : wptr + 1'b1;
            if (rd_acc) begin
                rd_word <= mem[rptr];
                rptr    <= (rptr == LAST_A) ? '0 : rptr + 1'b1;
            end
        end
    end

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && full && !rd_req) |=> (count == FULL_C)); // R3
    AST_EMPTY_READ: assert property (@(posedge clk) disable iff (rst)
        (rd_req && empty && !wr_en) |=> (!rd_valid && count == '0)); // R4
    AST_PAIR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rd_req && !full && !empty) |=> $stable(count)); // R11
endmodule

// File: rtl/pktq_hyst.sv
module pktq_hyst
    import pktq_pkg::*;
#(
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  cnt_t level,
    input  cnt_t on_lvl,
    input  cnt_t off_lvl,
    output logic flag
);
    cnt_t rise_at;
    assign rise_at = rise_level(on_lvl, off_lvl);

    always_ff @(posedge clk) begin
        if (rst)
            flag <= RST_VAL;
        else if (flag && level <= on_lvl)
            flag <= 1'b0;
        else if (!flag && level >= rise_at && level > on_lvl)
            flag <= 1'b1;
    end
endmodule

// File: rtl/pktq_hyst_fifo.sv
module pktq_hyst_fifo
    import pktq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [CNT_W-1:0]   afull_on,
    input  logic [CNT_W-1:0]   afull_off,
    input  logic [CNT_W-1:0]   aempty_on,
    input  logic [CNT_W-1:0]   aempty_off,
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               wr_sop,
    input  logic               wr_eop,
    input  logic [EMPTY_W-1:0] wr_empty,
    output logic               room_ok,
    output logic               overflow,
    input  logic               rd_req,
    output logic               rd_valid,
    output logic [DATA_W-1:0]  rd_data,
    output logic               rd_sop,
    output logic               rd_eop,
    output logic [EMPTY_W-1:0] rd_empty,
    output logic               data_ok
);
    localparam cnt_t FULL_C = cnt_t'(DEPTH);

    word_t in_word, out_word;
    cnt_t  count, count_nxt, free_nxt, free_now;
    logic  wr_drop;

    assign in_word = '{sop: wr_sop, eop: wr_eop, empty: wr_empty, data: wr_data};

    pktq_store u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_word   (in_word),
        .rd_req    (rd_req),
        .rd_valid  (rd_valid),
        .rd_word   (out_word),
        .count     (count),
        .count_nxt (count_nxt),
        .wr_drop   (wr_drop)
    );

    assign rd_data  = out_word.data;
    assign rd_sop   = out_word.sop;
    assign rd_eop   = out_word.eop;
    assign rd_empty = out_word.empty;

    assign free_nxt = FULL_C - count_nxt;
    assign free_now = FULL_C - count;

    pktq_hyst #(.RST_VAL(1'b1)) u_room (
        .clk     (clk),
        .rst     (rst),
        .level   (free_nxt),
        .on_lvl  (afull_on),
        .off_lvl (afull_off),
        .flag    (room_ok)
    );

    pktq_hyst #(.RST_VAL(1'b0)) u_data (
        .clk     (clk),
        .rst     (rst),
        .level   (count_nxt),
        .on_lvl  (aempty_on),
        .off_lvl (aempty_off),
        .flag    (data_ok)
    );

    always_ff @(posedge clk) begin
        if (rst)
            overflow <= 1'b0;
        else if (wr_drop)
            overflow <= 1'b1;
    end

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow); // R3
    AST_ROOM_BAND: assert property (@(posedge clk) disable iff (rst)
        ($stable(afull_on) && room_ok) |-> (free_now > afull_on)); // R5
    AST_DATA_BAND: assert property (@(posedge clk) disable iff (rst)
        ($stable(aempty_on) && data_ok) |-> (count > aempty_on)); // R7
    AST_VALID_TAIL: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> !rd_valid); // R9
    AST_STREAM: assert property (@(posedge clk) disable iff (rst)
        (rd_req && count != '0) |=> rd_valid); // R10
endmodule

// File: tb/pktq_hyst_fifo_test.sv
module pktq_hyst_fifo_test;
    import pktq_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst;
    cnt_t afull_on, afull_off, aempty_on, aempty_off;
    logic wr_en, wr_sop, wr_eop, rd_req;
    logic [DATA_W-1:0] wr_data;
    logic [EMPTY_W-1:0] wr_empty;
    logic room_ok, overflow, rd_valid, rd_sop, rd_eop, data_ok;
    logic [DATA_W-1:0] rd_data;
    logic [EMPTY_W-1:0] rd_empty;

    pktq_hyst_fifo uut (
        .clk(clk), .rst(rst),
        .afull_on(afull_on), .afull_off(afull_off),
        .aempty_on(aempty_on), .aempty_off(aempty_off),
        .wr_en(wr_en), .wr_data(wr_data), .wr_sop(wr_sop), .wr_eop(wr_eop), .wr_empty(wr_empty),
        .room_ok(room_ok), .overflow(overflow),
        .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data),
        .rd_sop(rd_sop), .rd_eop(rd_eop), .rd_empty(rd_empty), .data_ok(data_ok)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    word_t q[$];
    word_t exp_w;
    bit m_room, m_data, m_ovf, exp_valid;
    int in_pkt = 0;

    task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit next_flag(input bit cur, input int lvl, input int on_l, input int off_l);
        int rise;
        rise = (off_l < on_l) ? on_l : off_l;
        if (cur && lvl <= on_l) return 1'b0;
        if (!cur && lvl >= rise && lvl > on_l) return 1'b1;
        return cur;
    endfunction

    task automatic set_word(input bit en);
        wr_en    = en;
        wr_data  = {$urandom, $urandom};
        wr_sop   = (in_pkt == 0);
        wr_eop   = ($urandom_range(0, 3) == 0);
        wr_empty = wr_eop ? 3'($urandom_range(0, 7)) : 3'd0;
    endtask

    // one clock: model the cycle, then compare at the next falling edge
    task automatic cycle();
        bit wacc, racc;
        word_t inw;
        inw  = '{sop: wr_sop, eop: wr_eop, empty: wr_empty, data: wr_data};
        wacc = wr_en && q.size() < DEPTH;
        racc = rd_req && q.size() > 0;
        if (wr_en && q.size() == DEPTH) m_ovf = 1'b1;
        exp_valid = racc;
        if (racc) exp_w = q.pop_front();
        if (wacc) begin
            q.push_back(inw);
            in_pkt = wr_eop ? 0 : 1;
        end
        m_room = next_flag(m_room, DEPTH - q.size(), int'(afull_on), int'(afull_off));
        m_data = next_flag(m_data, q.size(), int'(aempty_on), int'(aempty_off));
        @(negedge clk);
        chk("R4 R9 R10 rd_valid", 96'(rd_valid), 96'(exp_valid));
        if (exp_valid)
            chk("R2 word", 96'({rd_sop, rd_eop, rd_empty, rd_data}), 96'(exp_w));
        chk("R5 R6 R11 room_ok", 96'(room_ok), 96'(m_room));
        chk("R7 R8 R11 data_ok", 96'(data_ok), 96'(m_data));
        chk("R3 overflow", 96'(overflow), 96'(m_ovf));
    endtask

    task automatic do_reset(input int fon, input int foff, input int eon, input int eoff);
        rst = 1'b1; wr_en = 0; rd_req = 0;
        afull_on = cnt_t'(fon); afull_off = cnt_t'(foff);
        aempty_on = cnt_t'(eon); aempty_off = cnt_t'(eoff);
        repeat (2) @(negedge clk);
        rst = 1'b0;
        q.delete(); in_pkt = 0;
        m_room = 1; m_data = 0; m_ovf = 0;
        chk("R1 rd_valid", 96'(rd_valid), 96'd0);
        chk("R1 room_ok", 96'(room_ok), 96'd1);
        chk("R1 data_ok", 96'(data_ok), 96'd0);
        chk("R1 overflow", 96'(overflow), 96'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        wr_en = 0; rd_req = 0; wr_data = '0; wr_sop = 0; wr_eop = 0; wr_empty = '0;
        do_reset(4, 8, 2, 6);

        // R8 then R5: fill to 16
        for (int i = 0; i < DEPTH; i++) begin
            set_word(1); rd_req = 0; cycle();
            if (i == 5) chk("R8 data_ok at occupancy 6", 96'(data_ok), 96'd1);
            if (i == 11) chk("R5 room_ok at free 4", 96'(room_ok), 96'd0);
        end
        // R3: write while full with a read in the same cycle is still dropped
        set_word(1); rd_req = 1; cycle();
        chk("R3 overflow after full write", 96'(overflow), 96'd1);
        set_word(0); rd_req = 0; cycle();
        chk("R9 single tail word", 96'(rd_valid), 96'd0);
        // R6 and R7: drain
        for (int i = 0; i < DEPTH; i++) begin
            set_word(0); rd_req = 1; cycle();
            if (q.size() == 8) chk("R6 room_ok back at free 8", 96'(room_ok), 96'd1);
            if (q.size() == 2) chk("R7 data_ok low at occupancy 2", 96'(data_ok), 96'd0);
        end
        // R4: read from empty
        set_word(0); rd_req = 1; cycle();
        chk("R4 no word from empty", 96'(rd_valid), 96'd0);
        // R11: paired read and write at occupancy 1
        set_word(1); rd_req = 0; cycle();
        set_word(1); rd_req = 1; cycle();
        chk("R11 paired transfer valid", 96'(rd_valid), 96'd1);

        // off levels below on levels
        do_reset(5, 1, 3, 0);
        for (int i = 0; i < 12; i++) begin
            set_word(1); rd_req = 0; cycle();
            if (i == 3) chk("R8 data_ok rises at 4 with low off", 96'(data_ok), 96'd1);
        end
        for (int i = 0; i < 12; i++) begin set_word(0); rd_req = 1; cycle(); end

        // constrained random phases
        for (int blk = 0; blk < 6; blk++) begin
            int fon, eon, wp, rp;
            fon = $urandom_range(1, 6);
            eon = $urandom_range(0, 5);
            do_reset(fon, $urandom_range(0, 12), eon, $urandom_range(0, 12));
            wp = $urandom_range(30, 80);
            rp = $urandom_range(30, 80);
            for (int c = 0; c < 1500; c++) begin
                set_word($urandom_range(0, 99) < wp);
                rd_req = ($urandom_range(0, 99) < rp);
                cycle();
            end
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule